// File: doc/BRIEF.md
# Ethernet Link Bring-Up Sequencer

This block takes one Ethernet port from power-on reset to the point where traffic may flow. It holds the port's active-low reset and its reconfiguration reset asserted while the port loads its configuration and confirms that reset has taken effect. It then releases both resets in the same cycle. After that it waits, in a fixed order, for auto-negotiation, link training, transmit-lane stability and receive-side PCS readiness. Only after every step has passed does it raise a ready flag that lets the traffic source start.

Every status flag from the MAC/PHY side is resynchronised through two flops before the state machine uses it. Each wait step is guarded by a cycle counter whose limit comes in on a port. A step that stays stuck past that limit parks the sequencer in an error state, and only a block reset clears it. If the link loses any of its four readiness flags while in data mode, the sequencer goes back to reset and runs the whole chain again.

Top module: `linkup_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `port_rst_n` is 0, `recfg_rst` is 1, `data_ready` is 0, `seq_err` is 0 and `link_state` is 0.
- R2: `link_state` encoding: 0 reset-assert, 1 wait-config, 2 wait-ack, 3 wait-negotiation, 4 wait-training, 5 wait-TX, 6 wait-RX, 7 data mode, 8 error. Reset-assert lasts exactly one cycle and is followed by wait-config.
- R3: Wait-config advances to wait-ack only when `cfg_loaded` is 1. Wait-ack advances to wait-negotiation only when `reset_ack_n` is 0.
- R4: Both resets stay asserted in states 0 to 2. They are released together (`port_rst_n`=1, `recfg_rst`=0) on entry to state 3 and stay released through state 7.
- R5: Negotiation is taken before training. A high `train_done` does not move state 3. Once `neg_done` is seen, state 4 is entered, and it is left as soon as `train_done` is 1.
- R6: State 5 advances only when `tx_stable` is 1. State 6 advances to data mode only when `rx_ready` is 1. An early `rx_ready` does not move state 5.
- R7: `data_ready` is 1 exactly while `link_state` is 7.
- R8: Each status input passes through two synchronising flops. A change takes effect in `link_state` at the third rising edge after the input changes, and not before.
- R9: With `timeout_limit` L nonzero, a wait state (1 to 6) whose condition stays false is left for state 8 after L+1 cycles in it. L=0 disables the timeout.
- R10: In state 8, `seq_err` is 1, both resets are asserted and `data_ready` is 0. This holds whatever the inputs do, until `rst`.
- R11: In data mode, a 0 on any one of `neg_done`, `train_done`, `tx_stable` or `rx_ready` sends the sequencer to state 0 with `data_ready` cleared and both resets asserted. `cfg_loaded` and `reset_ack_n` are ignored in data mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| timeout_limit | input | TW | Cycles allowed per wait state; 0 disables |
| cfg_loaded | input | 1 | Configuration loading finished |
| reset_ack_n | input | 1 | Active-low reset acknowledge from the port |
| neg_done | input | 1 | Auto-negotiation complete |
| train_done | input | 1 | Link training complete |
| tx_stable | input | 1 | TX lanes stable |
| rx_ready | input | 1 | RX PCS ready |
| port_rst_n | output | 1 | Active-low global reset to the port |
| recfg_rst | output | 1 | Active-high reconfiguration reset |
| link_state | output | 4 | Current sequencer state (R2 encoding) |
| data_ready | output | 1 | Traffic may start |
| seq_err | output | 1 | Timeout error, sticky until reset |

## Verification
A status edge reaches `link_state` and the registered outputs at the third rising edge after it is driven. So the bench changes inputs on a falling edge and checks the old state two falling edges later and the new state on the third. A chained step, where the next condition is already true, shows one falling edge after that. For a timeout the stuck state is still present L+1 falling edges after entry and the error state shows on the next. Bring-up delays, the early arrival of later flags and the flag that is dropped in data mode are drawn at random with a fixed seed. The expected state at each of these points comes from bench functions.

// File: rtl/linkup_pkg.sv
package linkup_pkg;

    typedef enum logic [3:0] {
        S_RST_ASSERT = 4'd0,
        S_WAIT_CFG   = 4'd1,
        S_WAIT_ACK   = 4'd2,
        S_WAIT_NEG   = 4'd3,
        S_WAIT_TRN   = 4'd4,
        S_WAIT_TX    = 4'd5,
        S_WAIT_RX    = 4'd6,
        S_DATA       = 4'd7,
        S_ERROR      = 4'd8
    } lu_state_e;

    localparam int NSTAT   = 6;
    localparam int IDX_CFG = 0;
    localparam int IDX_ACK = 1;
    localparam int IDX_NEG = 2;
    localparam int IDX_TRN = 3;
    localparam int IDX_TX  = 4;
    localparam int IDX_RX  = 5;

    // Reset value of the synchronised flags: acknowledge idles high.
    localparam logic [NSTAT-1:0] STAT_IDLE = 6'b00_0010;

    function automatic logic is_wait(lu_state_e s);
        return (s >= S_WAIT_CFG) && (s <= S_WAIT_RX);
    endfunction

    function automatic logic resets_released(lu_state_e s);
        return (s >= S_WAIT_NEG) && (s <= S_DATA);
    endfunction

endpackage

// File: rtl/linkup_sync.sv
module linkup_sync #(
    parameter int          W       = 6,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q, sync_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= RST_VAL[i];
                sync_q <= RST_VAL[i];
            end else begin
                meta_q <= d[i];
                sync_q <= meta_q;
            end
        end
        assign q[i] = sync_q;
    end
endmodule

// File: rtl/linkup_timer.sv
module linkup_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          en,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    localparam logic [TW-1:0] CNT_MAX = '1;

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (en && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + TW'(1);
        end
    end

    assign expired = en && (limit != '0) && (cnt_q == limit);

    // R9: each new wait state starts counting from zero
    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0));

    // R9: the count never moves while disabled
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/linkup_fsm.sv
module linkup_fsm
    import linkup_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NSTAT-1:0] stat_i,
    input  logic             expired_i,
    output logic             tmr_clr_o,
    output logic             tmr_en_o,
    output lu_state_e        state_o,
    output logic             port_rst_n_o,
    output logic             recfg_rst_o,
    output logic             data_ready_o,
    output logic             err_o
);
    lu_state_e state_q, state_d;
    logic      link_ok;
    logic      port_rst_n_q, recfg_rst_q, data_ready_q, err_q;

    assign link_ok = stat_i[IDX_NEG] && stat_i[IDX_TRN] &&
                     stat_i[IDX_TX]  && stat_i[IDX_RX];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_RST_ASSERT: state_d = S_WAIT_CFG;
            S_WAIT_CFG:   if (stat_i[IDX_CFG])  state_d = S_WAIT_ACK;
            S_WAIT_ACK:   if (!stat_i[IDX_ACK]) state_d = S_WAIT_NEG;
            S_WAIT_NEG:   if (stat_i[IDX_NEG])  state_d = S_WAIT_TRN;
            S_WAIT_TRN:   if (stat_i[IDX_TRN])  state_d = S_WAIT_TX;
            S_WAIT_TX:    if (stat_i[IDX_TX])   state_d = S_WAIT_RX;
            S_WAIT_RX:    if (stat_i[IDX_RX])   state_d = S_DATA;
            S_DATA:       if (!link_ok)         state_d = S_RST_ASSERT;
            S_ERROR:      state_d = S_ERROR;
            default:      state_d = S_RST_ASSERT;
        endcase
        if (is_wait(state_q) && (state_d == state_q) && expired_i) begin
            state_d = S_ERROR;
        end
    end

    assign tmr_clr_o = (state_d != state_q);
    assign tmr_en_o  = is_wait(state_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= S_RST_ASSERT;
            port_rst_n_q <= 1'b0;
            recfg_rst_q  <= 1'b1;
            data_ready_q <= 1'b0;
            err_q        <= 1'b0;
        end else begin
            state_q      <= state_d;
            port_rst_n_q <= resets_released(state_d);
            recfg_rst_q  <= !resets_released(state_d);
            data_ready_q <= (state_d == S_DATA);
            err_q        <= (state_d == S_ERROR);
        end
    end

    assign state_o      = state_q;
    assign port_rst_n_o = port_rst_n_q;
    assign recfg_rst_o  = recfg_rst_q;
    assign data_ready_o = data_ready_q;
    assign err_o        = err_q;

    // R4: the port reset is released only on entering wait-negotiation
    p_release_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(port_rst_n_q) |-> (state_q == S_WAIT_NEG) && !recfg_rst_q);

    // R5: training wait is reached only through negotiation
    p_order_trn_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_WAIT_TRN) |->
            ($past(state_q) == S_WAIT_NEG) || ($past(state_q) == S_WAIT_TRN));

    // R6: data mode only follows an RX-ready observation
    p_rx_before_ready_r6: assert property (@(posedge clk) disable iff (rst)
        data_ready_q |-> $past(stat_i[IDX_RX]));

    // R7: ready flag is tied to data mode
    p_ready_state_r7: assert property (@(posedge clk) disable iff (rst)
        data_ready_q |-> (state_q == S_DATA));

    // R10: the error state is sticky and flagged
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_ERROR) |=> (state_q == S_ERROR) && err_q && !port_rst_n_q);
endmodule

// File: rtl/linkup_seq.sv
module linkup_seq
    import linkup_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] timeout_limit,
    input  logic          cfg_loaded,
    input  logic          reset_ack_n,
    input  logic          neg_done,
    input  logic          train_done,
    input  logic          tx_stable,
    input  logic          rx_ready,
    output logic          port_rst_n,
    output logic          recfg_rst,
    output logic [3:0]    link_state,
    output logic          data_ready,
    output logic          seq_err
);
    logic [NSTAT-1:0] stat_raw, stat_s;
    logic             tmr_clr, tmr_en, tmr_exp;
    lu_state_e        state;

    always_comb begin
        stat_raw          = '0;
        stat_raw[IDX_CFG] = cfg_loaded;
        stat_raw[IDX_ACK] = reset_ack_n;
        stat_raw[IDX_NEG] = neg_done;
        stat_raw[IDX_TRN] = train_done;
        stat_raw[IDX_TX]  = tx_stable;
        stat_raw[IDX_RX]  = rx_ready;
    end

    linkup_sync #(.W(NSTAT), .RST_VAL(STAT_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (stat_raw),
        .q   (stat_s)
    );

    linkup_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (tmr_clr),
        .en      (tmr_en),
        .limit   (timeout_limit),
        .expired (tmr_exp)
    );

    linkup_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .stat_i       (stat_s),
        .expired_i    (tmr_exp),
        .tmr_clr_o    (tmr_clr),
        .tmr_en_o     (tmr_en),
        .state_o      (state),
        .port_rst_n_o (port_rst_n),
        .recfg_rst_o  (recfg_rst),
        .data_ready_o (data_ready),
        .err_o        (seq_err)
    );

    assign link_state = state;
endmodule

// File: tb/linkup_seq_tb.sv
module linkup_seq_tb;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [TW-1:0] timeout_limit = '0;
    logic          cfg_loaded = 1'b0, reset_ack_n = 1'b1;
    logic          neg_done = 1'b0, train_done = 1'b0;
    logic          tx_stable = 1'b0, rx_ready = 1'b0;
    logic          port_rst_n, recfg_rst, data_ready, seq_err;
    logic [3:0]    link_state;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    linkup_seq #(.TW(TW)) u_dut (
        .clk(clk), .rst(rst), .timeout_limit(timeout_limit),
        .cfg_loaded(cfg_loaded), .reset_ack_n(reset_ack_n),
        .neg_done(neg_done), .train_done(train_done),
        .tx_stable(tx_stable), .rx_ready(rx_ready),
        .port_rst_n(port_rst_n), .recfg_rst(recfg_rst),
        .link_state(link_state), .data_ready(data_ready), .seq_err(seq_err)
    );

    function automatic int exp_rst_n(int s);
        return (s >= 3 && s <= 7) ? 1 : 0;
    endfunction

    function automatic int exp_ready(int s);
        return (s == 7) ? 1 : 0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // state plus every output that follows from it
    task automatic chk_state(input string req, input int s);
        chk(req, int'(link_state), s);
        chk({req, " port_rst_n"}, int'(port_rst_n), exp_rst_n(s));
        chk({req, " recfg_rst"}, int'(recfg_rst), 1 - exp_rst_n(s));
        chk({req, " data_ready"}, int'(data_ready), exp_ready(s));
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic idle_inputs;
        cfg_loaded = 0; reset_ack_n = 1;
        neg_done = 0; train_done = 0; tx_stable = 0; rx_ready = 0;
    endtask

    task automatic do_reset(input int lim);
        timeout_limit = TW'(lim);
        idle_inputs();
        rst = 1;
        step(3);
        chk_state("R1 in reset", 0);
        chk("R1 seq_err", int'(seq_err), 0);
        rst = 0;
        chk_state("R1 first cycle", 0);
        step(1);
        chk_state("R2 wait-config after reset-assert", 1);
    endtask

    task automatic bringup(input int d, input bit early_trn, input bit early_rx);
        step(d);
        chk_state("R3 holds without cfg", 1);
        cfg_loaded = 1;
        step(2);
        chk_state("R8 no move before third edge", 1);
        step(1);
        chk_state("R3 cfg advance, R4 resets held", 2);
        step(d);
        chk_state("R3 holds without ack", 2);
        reset_ack_n = 0;
        step(2);
        chk_state("R8 ack not yet seen", 2);
        step(1);
        chk_state("R4 release on wait-negotiation", 3);
        if (early_trn) begin
            train_done = 1;
            step(d + 3);
            chk_state("R5 training ignored before negotiation", 3);
        end
        neg_done = 1;
        step(3);
        chk_state("R5 negotiation seen", 4);
        if (early_trn) begin
            step(1);
            chk_state("R5 chained training", 5);
        end else begin
            step(d);
            chk_state("R5 waits for training", 4);
            train_done = 1;
            step(3);
            chk_state("R5 training seen", 5);
        end
        if (early_rx) begin
            rx_ready = 1;
            step(d + 3);
            chk_state("R6 rx ignored before tx", 5);
        end
        tx_stable = 1;
        step(3);
        chk_state("R6 tx seen", 6);
        if (early_rx) begin
            step(1);
            chk_state("R6 R7 chained data mode", 7);
        end else begin
            step(d);
            chk_state("R6 waits for rx", 6);
            rx_ready = 1;
            step(3);
            chk_state("R6 R7 data mode", 7);
        end
    endtask

    task automatic drop_flag(input int which);
        cfg_loaded = 0;
        reset_ack_n = 1;
        step(5);
        chk_state("R11 cfg/ack ignored in data mode", 7);
        case (which)
            0: neg_done = 0;
            1: train_done = 0;
            2: tx_stable = 0;
            default: rx_ready = 0;
        endcase
        step(2);
        chk_state("R8 drop not yet seen", 7);
        step(1);
        chk_state($sformatf("R11 drop flag %0d", which), 0);
        idle_inputs();
        step(1);
        chk_state("R2 reset-assert one cycle", 1);
        step(5);
        chk_state("R3 back in wait-config", 1);
    endtask

    task automatic chk_error_hold;
        chk_state("R10 error state", 8);
        chk("R10 seq_err", int'(seq_err), 1);
        cfg_loaded = 1; reset_ack_n = 0;
        neg_done = 1; train_done = 1; tx_stable = 1; rx_ready = 1;
        step(10);
        chk_state("R10 error sticky", 8);
        chk("R10 seq_err sticky", int'(seq_err), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd4242);
        do_reset(1000);

        for (int it = 0; it < 6; it++) begin
            int  d;
            bit  et, er;
            d  = 1 + int'($urandom % 20);
            et = (it == 0) ? 1'b1 : (it == 1) ? 1'b0 : 1'($urandom % 2);
            er = (it == 0) ? 1'b1 : (it == 1) ? 1'b0 : 1'($urandom % 2);
            bringup(d, et, er);
            drop_flag((it < 4) ? it : int'($urandom % 4));
        end

        // timeout in wait-config, limit 5: entry at negedge 1, error at 7
        do_reset(5);
        step(5);
        chk_state("R9 still waiting at L+1", 1);
        step(1);
        chk_state("R9 timeout to error", 8);
        chk_error_hold();

        // timeout in wait-training
        do_reset(5);
        cfg_loaded = 1;
        step(3);
        chk_state("R3 cfg", 2);
        reset_ack_n = 0;
        step(3);
        chk_state("R4 release", 3);
        neg_done = 1;
        step(3);
        chk_state("R5 negotiation", 4);
        step(5);
        chk_state("R9 training still waiting", 4);
        step(1);
        chk_state("R9 training timeout", 8);
        chk_error_hold();

        // limit 0 disables the timeout
        do_reset(0);
        step(60);
        chk_state("R9 disabled timeout", 1);
        chk("R9 no error", int'(seq_err), 0);

        summary();
        $finish;
    end
endmodule